// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear frame buffer held in word-addressed memory, with one pixel stored per memory word. It does two jobs. It can paint a rectangle with a single foreground colour, or it can move a rectangle of pixels from one place in the buffer to another. Software first loads the geometry, the direction, the colour, the write mask and the source selection through a small register write port. Writing the size register then launches the operation, and a status bit reports when the engine is working.

The engine walks the rectangle row by row. Within each row it visits the columns one at a time, and it can run in increasing or decreasing order on each axis. Software names the corner to start from and picks the directions, so an overlapping copy can be ordered to never read a pixel it has already overwritten. A copy fetches each source pixel over the memory request channel, waits for the in-order read response, and then writes the pixel to the destination. A fill only issues writes. Every write carries the programmed bit mask.

Top module: `rect_blit_engine`

## Requirements
- R1: While reset is low, and in the first cycle after it, status bit 0 is 0 and no memory request is valid.
- R2: The register offsets are: 0 pitch, 1 destination XY, 2 size, 3 direction, 4 source XY, 5 foreground colour, 6 write mask, 7 source select. In the XY registers, X sits in bits 31:16 and Y in bits 15:0. In the size register, width sits in bits 31:16 and height in bits 15:0. Pitch sits in bits 31:22 and counts in units of 8 pixels. A pixel lives at word FB_BASE + Y*pitch*8 + X.
- R3: A write to the size register with a nonzero width and height, made while idle, starts an operation. Status bit 0 is 1 from the next cycle, and it returns to 0 in the cycle after the last write is accepted.
- R4: With source select bit 0 clear, the engine writes the foreground colour exactly once to every pixel of the width by height rectangle and issues no reads.
- R5: Direction bit 0 set makes X increase along a row, and clear makes it decrease. Bit 1 does the same for Y between rows. Rows form the outer loop. The first write goes to the start corner taken from destination XY.
- R6: With source select bit 0 set, each destination write is preceded by exactly one source read, and it carries the returned data.
- R7: A copy between overlapping rectangles, run with X increasing when the destination X is at most the source X and Y increasing when the destination Y is at most the source Y, and started from the matching corners, leaves the destination equal to the original source contents.
- R8: Every write carries the write mask register on the mask output. A mask bit set means that bit of the word is written.
- R9: A size write with a zero width or a zero height starts nothing. Busy stays 0 and no memory request is made.
- R10: Register writes while busy are ignored, and the running operation and later operations keep the earlier values.
- R11: A valid memory request keeps its address, direction and data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Bit 0 busy, other bits zero |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | PW | Write data |
| mem_req_wmask | output | PW | Per-bit write enable |
| mem_rsp_valid | input | 1 | Read data valid, returned in order |
| mem_rsp_data | input | PW | Read data |

## Verification
The bench builds the engine with a 12-bit address, 16-bit pixels and a frame buffer base of 64, and uses a pitch of 4 (32 pixels per row). At that size the whole 4096-word memory can be compared with a reference image after every operation. This makes it practical to sweep every fill size from 1x1 to 3x3 in all four direction combinations. It also covers all nine overlap offsets of a 3x3 copy within one pixel, which are exactly the cases where a wrong traversal order corrupts the result. The memory model withholds ready on an irregular pattern, so requests are seen waiting across several cycles.

// File: rtl/blit_pkg.sv
// Shared constants and types for the rectangle fill/copy engine.
// Assumes a 32-bit register write port with 3-bit offsets.
package blit_pkg;
    localparam int COORD_W   = 16;
    localparam int PITCH_W   = 10;
    localparam int PITCH_LSB = 22;

    localparam logic [2:0] RA_PITCH = 3'd0;
    localparam logic [2:0] RA_DXY   = 3'd1;
    localparam logic [2:0] RA_DHW   = 3'd2;
    localparam logic [2:0] RA_DIR   = 3'd3;
    localparam logic [2:0] RA_SXY   = 3'd4;
    localparam logic [2:0] RA_FG    = 3'd5;
    localparam logic [2:0] RA_MASK  = 3'd6;
    localparam logic [2:0] RA_SRC   = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WRITE
    } blit_state_e;
endpackage

// File: rtl/blit_addr_gen.sv
// Maps a pixel coordinate to a word address: BASE + y*pitch*8 + x.
// Purely combinational; assumes one pixel per word and wraps modulo 2**AW.
module blit_addr_gen #(
    parameter int AW = 20,
    parameter int CW = 16,
    parameter int PITCH_W = 10,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic [CW-1:0]      x,
    input  logic [CW-1:0]      y,
    input  logic [PITCH_W-1:0] pitch,
    output logic [AW-1:0]      addr
);
    localparam int PROD_W = CW + PITCH_W + 3;
    localparam int SUM_W  = (PROD_W > AW) ? PROD_W : AW;

    logic [SUM_W-1:0] row_off;
    logic [SUM_W-1:0] full;

    // Row offset in words, then the full sum.
    always_comb begin
        row_off = (SUM_W'(y) * SUM_W'(pitch)) << 3;
        full    = SUM_W'(BASE) + row_off + SUM_W'(x);
    end

    assign addr = full[AW-1:0];
endmodule

// File: rtl/blit_walker.sv
// Steps destination and source coordinates through a rectangle,
// with rows as the outer loop and columns as the inner loop.
// Assumes load and step are never high together and that width and height are nonzero at load.
module blit_walker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] ld_dx,
    input  logic [CW-1:0] ld_dy,
    input  logic [CW-1:0] ld_sx,
    input  logic [CW-1:0] ld_sy,
    input  logic [CW-1:0] ld_w,
    input  logic [CW-1:0] ld_h,
    input  logic          ld_lr,
    input  logic          ld_tb,
    output logic [CW-1:0] dx,
    output logic [CW-1:0] dy,
    output logic [CW-1:0] sx,
    output logic [CW-1:0] sy,
    output logic          last
);
    logic [CW-1:0] w_q, col_left, row_left, dx0_q, sx0_q;
    logic          lr_q, tb_q;

    // Coordinate and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0; col_left <= '0; row_left <= '0;
            dx0_q <= '0; sx0_q <= '0; lr_q <= 1'b0; tb_q <= 1'b0;
            dx <= '0; dy <= '0; sx <= '0; sy <= '0;
        end else if (load) begin
            w_q      <= ld_w;
            col_left <= ld_w;
            row_left <= ld_h;
            dx0_q    <= ld_dx;
            sx0_q    <= ld_sx;
            lr_q     <= ld_lr;
            tb_q     <= ld_tb;
            dx <= ld_dx; dy <= ld_dy; sx <= ld_sx; sy <= ld_sy;
        end else if (step) begin
            if (col_left == CW'(1)) begin
                col_left <= w_q;
                row_left <= row_left - CW'(1);
                dx <= dx0_q;
                sx <= sx0_q;
                dy <= tb_q ? dy + CW'(1) : dy - CW'(1);
                sy <= tb_q ? sy + CW'(1) : sy - CW'(1);
            end else begin
                col_left <= col_left - CW'(1);
                dx <= lr_q ? dx + CW'(1) : dx - CW'(1);
                sx <= lr_q ? sx + CW'(1) : sx - CW'(1);
            end
        end
    end

    assign last = (col_left == CW'(1)) && (row_left == CW'(1));

    // R5: the end of a row reloads the column count to the width.
    a_r5_row_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && col_left == CW'(1)) |=> (col_left == w_q));

    // R5: a step inside a row moves X by one in the chosen direction.
    a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && col_left != CW'(1)) |=>
        ($past(lr_q) ? (dx == $past(dx) + CW'(1)) : (dx == $past(dx) - CW'(1))));
endmodule

// File: rtl/rect_blit_engine.sv
// Rectangle fill and copy engine for a linear frame buffer.
// Holds the programming registers, sequences memory reads and writes
// with one request outstanding, and assumes in-order read responses.
module rect_blit_engine #(
    parameter int AW = 20,
    parameter int PW = 32,
    parameter logic [AW-1:0] FB_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   status,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [PW-1:0] mem_req_wdata,
    output logic [PW-1:0] mem_req_wmask,
    input  logic          mem_rsp_valid,
    input  logic [PW-1:0] mem_rsp_data
);
    import blit_pkg::*;

    localparam int CW = COORD_W;

    blit_state_e       state;
    logic              busy, start, step, last, have_pix;
    logic [PITCH_W-1:0] pitch_q;
    logic [31:0]       dxy_q, sxy_q;
    logic [1:0]        dir_q;
    logic [PW-1:0]     fg_q, mask_q, pix_q;
    logic              copy_q;
    logic [CW-1:0]     cur_dx, cur_dy, cur_sx, cur_sy;
    logic [AW-1:0]     dst_addr, src_addr;

    assign busy   = (state != ST_IDLE);
    assign status = {31'b0, busy};
    assign start  = reg_we && !busy && (reg_addr == RA_DHW)
                    && (reg_wdata[31:16] != '0) && (reg_wdata[15:0] != '0);

    // Programming registers; only written while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pitch_q <= '0; dxy_q <= '0; sxy_q <= '0; dir_q <= 2'b11;
            fg_q <= '0; mask_q <= '1; copy_q <= 1'b0;
        end else if (reg_we && !busy) begin
            case (reg_addr)
                RA_PITCH: pitch_q <= reg_wdata[PITCH_LSB +: PITCH_W];
                RA_DXY:   dxy_q   <= reg_wdata;
                RA_DIR:   dir_q   <= reg_wdata[1:0];
                RA_SXY:   sxy_q   <= reg_wdata;
                RA_FG:    fg_q    <= reg_wdata[PW-1:0];
                RA_MASK:  mask_q  <= reg_wdata[PW-1:0];
                RA_SRC:   copy_q  <= reg_wdata[0];
                default:  ;
            endcase
        end
    end

    blit_walker #(.CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(start), .step(step),
        .ld_dx(dxy_q[31:16]), .ld_dy(dxy_q[15:0]),
        .ld_sx(sxy_q[31:16]), .ld_sy(sxy_q[15:0]),
        .ld_w(reg_wdata[31:16]), .ld_h(reg_wdata[15:0]),
        .ld_lr(dir_q[0]), .ld_tb(dir_q[1]),
        .dx(cur_dx), .dy(cur_dy), .sx(cur_sx), .sy(cur_sy), .last(last)
    );

    blit_addr_gen #(.AW(AW), .CW(CW), .PITCH_W(PITCH_W), .BASE(FB_BASE)) u_dst_addr (
        .x(cur_dx), .y(cur_dy), .pitch(pitch_q), .addr(dst_addr)
    );

    blit_addr_gen #(.AW(AW), .CW(CW), .PITCH_W(PITCH_W), .BASE(FB_BASE)) u_src_addr (
        .x(cur_sx), .y(cur_sy), .pitch(pitch_q), .addr(src_addr)
    );

    assign step = (state == ST_WRITE) && mem_req_ready && !last;

    // Operation sequencer: read (copy only), wait for data, write, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pix_q <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= copy_q ? ST_READ : ST_WRITE;
                ST_READ:  if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) begin
                              pix_q <= mem_rsp_data;
                              state <= ST_WRITE;
                          end
                ST_WRITE: if (mem_req_ready) begin
                              if (last)        state <= ST_IDLE;
                              else if (copy_q) state <= ST_READ;
                              else             state <= ST_WRITE;
                          end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request outputs decoded from the sequencer state.
    always_comb begin
        mem_req_valid = (state == ST_READ) || (state == ST_WRITE);
        mem_req_we    = (state == ST_WRITE);
        mem_req_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
        mem_req_wdata = copy_q ? pix_q : fg_q;
        mem_req_wmask = mask_q;
    end

    // Tracks whether a read response has arrived since the last write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            have_pix <= 1'b0;
        else if (mem_rsp_valid)
            have_pix <= 1'b1;
        else if (mem_req_valid && mem_req_we && mem_req_ready)
            have_pix <= 1'b0;
    end

    // R1: reset leaves the engine idle with no request.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!mem_req_valid && !status[0]));

    // R3: an accepted start raises busy on the next cycle.
    a_r3_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> status[0]);

    // R3: the final accepted write returns the engine to idle.
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && mem_req_ready && last) |=> !status[0]);

    // R6: a copy write only goes out after its source read returned.
    a_r6_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && copy_q) |-> have_pix);

    // R9: a size write with a zero field leaves the engine idle.
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !busy && reg_addr == RA_DHW &&
         (reg_wdata[31:16] == '0 || reg_wdata[15:0] == '0)) |=> !status[0]);

    // R10: register writes while busy change nothing.
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> ($stable(fg_q) && $stable(mask_q) && $stable(dxy_q) && $stable(copy_q)));

    // R11: a pending request holds until accepted.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
endmodule

// File: tb/sim_rect_blit_engine.sv
module sim_rect_blit_engine;
    import blit_pkg::*;

    localparam int AW = 12;
    localparam int PW = 16;
    localparam int MEMD = 4096;
    localparam int BASE = 64;
    localparam int ROWPX = 32;   // pitch 4 units of 8 pixels

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] status;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [PW-1:0] mem_req_wdata, mem_req_wmask;
    logic mem_rsp_valid = 1'b0;
    logic [PW-1:0] mem_rsp_data = '0;

    logic [PW-1:0] mem   [0:MEMD-1];
    logic [PW-1:0] ref_m [0:MEMD-1];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_rd = 0, n_wr = 0, first_wr = -1, rd_since_wr = 0, order_err = 0, hold_err = 0;
    bit seen_wr = 0, copy_mode = 0, prev_pend = 0, prev_we = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [7:0] lfsr = 8'h5A;

    rect_blit_engine #(.AW(AW), .PW(PW), .FB_BASE(12'(BASE))) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status(status), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_wmask(mem_req_wmask), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #4 clk = ~clk;

    // Irregular ready pattern, changed away from the active edge.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready = ~(lfsr[0] & lfsr[1]);
    end

    // Memory model, access monitor and watchdog.
    always @(posedge clk) begin
        cyc++;
        mem_rsp_valid <= 1'b0;
        if (rst_n) begin
            if (prev_pend && (!mem_req_valid || mem_req_addr != prev_addr || mem_req_we != prev_we))
                hold_err++;
            prev_pend = mem_req_valid && !mem_req_ready;
            prev_addr = mem_req_addr;
            prev_we   = mem_req_we;
        end
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] <= (mem[mem_req_addr] & ~mem_req_wmask) | (mem_req_wdata & mem_req_wmask);
                n_wr++;
                if (!seen_wr) begin first_wr = int'(mem_req_addr); seen_wr = 1; end
                if (copy_mode && rd_since_wr != 1) order_err++;
                rd_since_wr = 0;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr];
                n_rd++;
                rd_since_wr++;
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int pa(int x, int y);
        return (BASE + y * ROWPX + x) % MEMD;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (status[0]) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_rd = 0; n_wr = 0; seen_wr = 0; rd_since_wr = 0; order_err = 0; first_wr = -1;
    endtask

    function automatic int mismatches();
        int n = 0;
        for (int i = 0; i < MEMD; i++) if (mem[i] !== ref_m[i]) n++;
        return n;
    endfunction

    task automatic do_fill(input int x, input int y, input int w, input int h,
                           input bit lr, input bit tb, input int fg, input int mask);
        int cx, cy;
        cx = lr ? x : x + w - 1;
        cy = tb ? y : y + h - 1;
        copy_mode = 0;
        wr(RA_SRC, 32'd0);
        wr(RA_FG, 32'(fg));
        wr(RA_MASK, 32'(mask));
        wr(RA_DIR, {30'd0, tb, lr});
        wr(RA_DXY, {16'(cx), 16'(cy)});
        clear_counts();
        wr(RA_DHW, {16'(w), 16'(h)});
        chk(status[0] == 1'b1, "R3 busy after start", int'(status[0]), 1);
        wait_idle();
        for (int j = 0; j < h; j++)
            for (int i = 0; i < w; i++)
                ref_m[pa(x+i, y+j)] = (ref_m[pa(x+i, y+j)] & ~PW'(mask)) | (PW'(fg) & PW'(mask));
        chk(mismatches() == 0, "R4 R8 fill image", mismatches(), 0);
        chk(n_wr == w*h && n_rd == 0, "R4 fill access count", n_wr*1000+n_rd, w*h*1000);
        chk(first_wr == pa(cx, cy), "R2 R5 first write at start corner", first_wr, pa(cx, cy));
    endtask

    task automatic do_copy(input int sx0, input int sy0, input int dx0, input int dy0,
                           input int w, input int h, input int mask);
        logic [PW-1:0] snap [0:15][0:15];
        bit lr, tb;
        int scx, scy, dcx, dcy;
        lr = (dx0 <= sx0);
        tb = (dy0 <= sy0);
        scx = lr ? sx0 : sx0 + w - 1;  scy = tb ? sy0 : sy0 + h - 1;
        dcx = lr ? dx0 : dx0 + w - 1;  dcy = tb ? dy0 : dy0 + h - 1;
        copy_mode = 1;
        wr(RA_SRC, 32'd1);
        wr(RA_MASK, 32'(mask));
        wr(RA_DIR, {30'd0, tb, lr});
        wr(RA_SXY, {16'(scx), 16'(scy)});
        wr(RA_DXY, {16'(dcx), 16'(dcy)});
        clear_counts();
        wr(RA_DHW, {16'(w), 16'(h)});
        wait_idle();
        for (int j = 0; j < h; j++)
            for (int i = 0; i < w; i++)
                snap[i][j] = ref_m[pa(sx0+i, sy0+j)];
        for (int j = 0; j < h; j++)
            for (int i = 0; i < w; i++)
                ref_m[pa(dx0+i, dy0+j)] = (ref_m[pa(dx0+i, dy0+j)] & ~PW'(mask)) | (snap[i][j] & PW'(mask));
        chk(mismatches() == 0, "R7 R8 copy image", mismatches(), 0);
        chk(n_rd == w*h && n_wr == w*h, "R6 copy access count", n_wr*1000+n_rd, w*h*1001);
        chk(order_err == 0, "R6 one read before each write", order_err, 0);
        chk(first_wr == pa(dcx, dcy), "R5 copy first write at corner", first_wr, pa(dcx, dcy));
    endtask

    initial begin
        for (int i = 0; i < MEMD; i++) begin
            mem[i]   = PW'(i * 37 + 5);
            ref_m[i] = PW'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 32'd0, "R1 status in reset", int'(status), 0);
        chk(mem_req_valid == 1'b0, "R1 no request in reset", int'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 32'd0 && !mem_req_valid, "R1 idle after reset", int'(status), 0);

        wr(RA_PITCH, 32'd4 << PITCH_LSB);

        // R4 R5: sweep fill sizes and all directions
        for (int w = 1; w <= 3; w++)
            for (int h = 1; h <= 3; h++)
                for (int d = 0; d < 4; d++)
                    do_fill(3, 2, w, h, d[0], d[1], 16'h1000 + w*64 + h*8 + d, 16'hFFFF);

        // R8: partial write mask
        do_fill(5, 9, 4, 3, 1'b0, 1'b1, 16'hA5C3, 16'h0F0F);

        // R6 R7: all overlap offsets of a 3x3 copy
        for (int oy = -1; oy <= 1; oy++)
            for (int ox = -1; ox <= 1; ox++)
                do_copy(8, 6, 8 + ox, 6 + oy, 3, 3, 16'hFFFF);
        do_copy(2, 14, 20, 12, 4, 2, 16'hFF00);

        // R9: zero width and zero height
        copy_mode = 0;
        wr(RA_SRC, 32'd0);
        wr(RA_DXY, {16'd1, 16'd1});
        clear_counts();
        wr(RA_DHW, {16'd0, 16'd3});
        chk(status[0] == 1'b0, "R9 zero width stays idle", int'(status[0]), 0);
        wr(RA_DHW, {16'd3, 16'd0});
        chk(status[0] == 1'b0, "R9 zero height stays idle", int'(status[0]), 0);
        repeat (8) @(negedge clk);
        chk(n_rd + n_wr == 0, "R9 no memory access", n_rd + n_wr, 0);
        chk(mismatches() == 0, "R9 memory unchanged", mismatches(), 0);

        // R10: writes while busy are ignored
        wr(RA_FG, 32'h1234);
        wr(RA_MASK, 32'hFFFF);
        wr(RA_DIR, 32'd3);
        wr(RA_DXY, {16'd2, 16'd20});
        clear_counts();
        wr(RA_DHW, {16'd4, 16'd4});
        wr(RA_FG, 32'hBEEF);
        wr(RA_DXY, {16'd25, 16'd25});
        wr(RA_DHW, {16'd1, 16'd1});
        chk(status[0] == 1'b1, "R10 still busy during writes", int'(status[0]), 1);
        wait_idle();
        for (int j = 0; j < 4; j++)
            for (int i = 0; i < 4; i++) ref_m[pa(2+i, 20+j)] = 16'h1234;
        chk(mismatches() == 0, "R10 op used earlier values", mismatches(), 0);
        chk(n_wr == 16, "R10 second start ignored", n_wr, 16);
        wr(RA_DXY, {16'd10, 16'd10});
        wr(RA_DHW, {16'd1, 16'd1});
        wait_idle();
        ref_m[pa(10, 10)] = 16'h1234;
        chk(mem[pa(10, 10)] == 16'h1234, "R10 colour kept", int'(mem[pa(10, 10)]), 'h1234);

        chk(hold_err == 0, "R11 request held until ready", hold_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule